// File: doc/BRIEF.md
# Predicate Compare Write Unit

This block owns a file of 64 one-bit predicates and turns the outcome of compare operations into predicate updates. Each of its four request lanes carries an already evaluated relation result, the value of the qualifying predicate, a deferred-exception flag for the source operands, a compare type and two target predicate indices. The block decides, per target, whether a write happens and with what value, merges all lanes of a cycle into one update of the file and exposes the whole file as a flat vector.

Two families of compare type exist. Exclusive types (plain and unconditional) own their targets outright. One-sided types (AND, OR, OR-ANDCM) only ever push a predicate one way. So any number of them aimed at one predicate in the same cycle combine like a wired AND or wired OR. A predicate that receives an exclusive write together with any other write, or both a set and a clear, in one cycle is a conflict. That predicate keeps its value, and an error flag is raised.

Requests enter through per-lane valid bits and one shared ready. Ready is low only while reset is held. Otherwise every valid lane is taken in the cycle it is presented, and there is no back-pressure.

Top module: `predcmp_unit`

## Requirements
- R1: Plain type (code 0): when the qualifying predicate is 1, the first target takes the relation and the second its complement; when it is 0 neither target changes.
- R2: Unconditional type (code 1): both targets are written every time, the first with qp AND relation, the second with qp AND NOT relation.
- R3: AND type (code 2): when qp is 1 and the relation is 0 both targets are cleared; otherwise both keep their value.
- R4: OR type (code 3): when qp is 1 and the relation is 1 both targets are set; otherwise both keep their value.
- R5: OR-ANDCM type (code 4): when qp is 1 and the relation is 1 the first target is set and the second cleared; otherwise both keep their value.
- R6: When the NaT flag of a lane is 1, that lane acts as if its relation were 0.
- R7: Predicate 0 always reads 1; writes aimed at index 0 are dropped and never take part in conflict detection.
- R8: Lane l uses bits [3l+2:3l] of req_type and [6l+5:6l] of each target field; up to four lanes act in one cycle, and several one-sided writes of the same polarity to one predicate combine without error.
- R9: A predicate hit by an exclusive write plus any other write, or by both a set and a clear, in one cycle keeps its old value while other predicates update normally; conflict_err is 1 in the following cycle only.
- R10: Updates appear on pred_q after the next rising clock edge; reset sets predicate 0 to 1, all others to 0 and conflict_err to 0; with no valid lane the file holds.
- R11: Type codes 5 to 7 and lanes whose valid bit is 0 write nothing.
- R12: req_ready is 0 while reset is held and 1 otherwise; every valid lane is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Per-lane request valid |
| req_ready | output | 1 | Shared acceptance for all lanes |
| req_type | input | 12 | Per-lane compare type code, 3 bits each |
| req_qp | input | 4 | Per-lane qualifying predicate value |
| req_rel | input | 4 | Per-lane relation result |
| req_nat | input | 4 | Per-lane deferred-exception flag |
| req_dst1 | input | 24 | Per-lane first target index, 6 bits each |
| req_dst2 | input | 24 | Per-lane second target index, 6 bits each |
| pred_q | output | 64 | Current predicate file, bit i is predicate i |
| conflict_err | output | 1 | Write conflict seen in the previous cycle |

## Verification
The whole file is visible on pred_q, so any wrong stored bit shows at the ports in the cycle after the update that caused it. It stays visible until a later write masks it. A faulty merge or conflict decision shows either as a wrong bit or as a wrong conflict_err on the very next cycle. Random traffic confined to a few low indices makes collisions between lanes frequent. Directed steps pin each compare type, the NaT override and predicate 0.

// File: rtl/predcmp_pkg.sv
package predcmp_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    CMP_PLAIN = 3'd0,
    CMP_UNC   = 3'd1,
    CMP_AND   = 3'd2,
    CMP_OR    = 3'd3,
    CMP_ORCM  = 3'd4
  } cmp_kind_e;

  // One target write: active, exclusive class, value (set/clear for one-sided)
  typedef struct packed {
    logic en;
    logic excl;
    logic val;
  } tgt_wr_t;
endpackage

// File: rtl/predcmp_decode.sv
module predcmp_decode
  import predcmp_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic                 valid,
  input  logic [TYPE_W-1:0]    kind,
  input  logic                 qp,
  input  logic                 rel,
  input  logic                 nat,
  input  logic [IDXW-1:0]      dst1,
  input  logic [IDXW-1:0]      dst2,
  output tgt_wr_t              wr1,
  output tgt_wr_t              wr2
);
  logic rel_e;
  tgt_wr_t w1, w2;

  assign rel_e = rel & ~nat;

  always_comb begin
    w1 = '0;
    w2 = '0;
    case (kind)
      CMP_PLAIN: if (qp) begin
        w1 = '{en: 1'b1, excl: 1'b1, val: rel_e};
        w2 = '{en: 1'b1, excl: 1'b1, val: ~rel_e};
      end
      CMP_UNC: begin
        w1 = '{en: 1'b1, excl: 1'b1, val: qp & rel_e};
        w2 = '{en: 1'b1, excl: 1'b1, val: qp & ~rel_e};
      end
      CMP_AND: if (qp && !rel_e) begin
        w1 = '{en: 1'b1, excl: 1'b0, val: 1'b0};
        w2 = '{en: 1'b1, excl: 1'b0, val: 1'b0};
      end
      CMP_OR: if (qp && rel_e) begin
        w1 = '{en: 1'b1, excl: 1'b0, val: 1'b1};
        w2 = '{en: 1'b1, excl: 1'b0, val: 1'b1};
      end
      CMP_ORCM: if (qp && rel_e) begin
        w1 = '{en: 1'b1, excl: 1'b0, val: 1'b1};
        w2 = '{en: 1'b1, excl: 1'b0, val: 1'b0};
      end
      default: begin
        w1 = '0;
        w2 = '0;
      end
    endcase
  end

  always_comb begin
    wr1 = w1;
    wr2 = w2;
    if (!valid || dst1 == '0) wr1.en = 1'b0;
    if (!valid || dst2 == '0) wr2.en = 1'b0;
  end
endmodule

// File: rtl/predcmp_merge.sv
module predcmp_merge #(
  parameter int NPRED = 64,
  parameter int NWR   = 8,
  parameter int IDXW  = 6
) (
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR-1:0]       wr_excl,
  input  logic [NWR-1:0]       wr_val,
  input  logic [NWR*IDXW-1:0]  wr_idx,
  input  logic [NPRED-1:1]     cur,
  output logic [NPRED-1:1]     nxt,
  output logic [NPRED-1:1]     conf
);
  for (genvar i = 1; i < NPRED; i++) begin : g_pred
    logic seen, multi, ex_any, ex_val, set_any, clr_any, hit;
    always_comb begin
      seen = 1'b0; multi = 1'b0; ex_any = 1'b0; ex_val = 1'b0;
      set_any = 1'b0; clr_any = 1'b0; hit = 1'b0;
      for (int w = 0; w < NWR; w++) begin
        hit = wr_en[w] && (wr_idx[w*IDXW +: IDXW] == IDXW'(i));
        if (hit) begin
          if (seen) multi = 1'b1;
          seen = 1'b1;
          if (wr_excl[w]) begin
            ex_any = 1'b1;
            ex_val = ex_val | wr_val[w];
          end else if (wr_val[w]) begin
            set_any = 1'b1;
          end else begin
            clr_any = 1'b1;
          end
        end
      end
      conf[i] = (ex_any && multi) || (set_any && clr_any);
      if (conf[i])      nxt[i] = cur[i];
      else if (ex_any)  nxt[i] = ex_val;
      else if (set_any) nxt[i] = 1'b1;
      else if (clr_any) nxt[i] = 1'b0;
      else              nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/predcmp_file.sv
module predcmp_file #(
  parameter int NPRED = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPRED-1:1]  nxt,
  output logic [NPRED-1:0]  pred_q
);
  logic [NPRED-1:1] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= nxt;
  end

  assign pred_q = {store_q, 1'b1};
endmodule

// File: rtl/predcmp_unit.sv
module predcmp_unit
  import predcmp_pkg::*;
#(
  parameter int NPRED = 64,
  parameter int LANES = 4,
  localparam int IDXW = $clog2(NPRED),
  localparam int NWR  = 2 * LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        req_valid,
  output logic                    req_ready,
  input  logic [LANES*TYPE_W-1:0] req_type,
  input  logic [LANES-1:0]        req_qp,
  input  logic [LANES-1:0]        req_rel,
  input  logic [LANES-1:0]        req_nat,
  input  logic [LANES*IDXW-1:0]   req_dst1,
  input  logic [LANES*IDXW-1:0]   req_dst2,
  output logic [NPRED-1:0]        pred_q,
  output logic                    conflict_err
);
  logic [NWR-1:0]      wr_en, wr_excl, wr_val;
  logic [NWR*IDXW-1:0] wr_idx;
  logic [NPRED-1:1]    nxt, conf;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tgt_wr_t w1, w2;
    predcmp_decode #(.IDXW(IDXW)) u_dec (
      .valid (req_valid[l]),
      .kind  (req_type[l*TYPE_W +: TYPE_W]),
      .qp    (req_qp[l]),
      .rel   (req_rel[l]),
      .nat   (req_nat[l]),
      .dst1  (req_dst1[l*IDXW +: IDXW]),
      .dst2  (req_dst2[l*IDXW +: IDXW]),
      .wr1   (w1),
      .wr2   (w2)
    );
    assign wr_en[2*l]    = w1.en;
    assign wr_excl[2*l]  = w1.excl;
    assign wr_val[2*l]   = w1.val;
    assign wr_idx[2*l*IDXW +: IDXW] = req_dst1[l*IDXW +: IDXW];
    assign wr_en[2*l+1]   = w2.en;
    assign wr_excl[2*l+1] = w2.excl;
    assign wr_val[2*l+1]  = w2.val;
    assign wr_idx[(2*l+1)*IDXW +: IDXW] = req_dst2[l*IDXW +: IDXW];
  end

  predcmp_merge #(.NPRED(NPRED), .NWR(NWR), .IDXW(IDXW)) u_merge (
    .wr_en   (wr_en),
    .wr_excl (wr_excl),
    .wr_val  (wr_val),
    .wr_idx  (wr_idx),
    .cur     (pred_q[NPRED-1:1]),
    .nxt     (nxt),
    .conf    (conf)
  );

  predcmp_file #(.NPRED(NPRED)) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .nxt    (nxt),
    .pred_q (pred_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_err <= 1'b0;
      req_ready    <= 1'b0;
    end else begin
      conflict_err <= |conf;
      req_ready    <= 1'b1;
    end
  end
endmodule

// File: rtl/predcmp_unit_chk.sv
module predcmp_unit_chk #(
  parameter int NPRED = 64,
  parameter int LANES = 4,
  localparam int IDXW = $clog2(NPRED)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LANES-1:0]      req_valid,
  input logic                  req_ready,
  input logic [LANES*3-1:0]    req_type,
  input logic [LANES-1:0]      req_qp,
  input logic [LANES-1:0]      req_rel,
  input logic [LANES-1:0]      req_nat,
  input logic [LANES*IDXW-1:0] req_dst1,
  input logic [LANES*IDXW-1:0] req_dst2,
  input logic [NPRED-1:0]      pred_q,
  input logic                  conflict_err
);
  logic only_or, only_and, lone_unc;
  logic [IDXW-1:0] d1_0, d2_0;

  assign d1_0 = req_dst1[IDXW-1:0];
  assign d2_0 = req_dst2[IDXW-1:0];

  always_comb begin
    only_or  = 1'b1;
    only_and = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (req_valid[l] && req_type[l*3 +: 3] != 3'd3) only_or  = 1'b0;
      if (req_valid[l] && req_type[l*3 +: 3] != 3'd2) only_and = 1'b0;
    end
  end

  assign lone_unc = (req_valid == LANES'(1)) && (req_type[2:0] == 3'd1) &&
                    (d1_0 != d2_0) && (d1_0 != '0);

  AST_P0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_q[0]); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> $stable(pred_q)); // R10
  AST_OR_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    only_or |=> ((~pred_q & $past(pred_q)) == '0)); // R4
  AST_AND_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    only_and |=> ((pred_q & ~$past(pred_q)) == '0)); // R3
  AST_UNC_FIRST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    lone_unc |=> (pred_q[$past(d1_0)] == $past(req_qp[0] & req_rel[0] & ~req_nat[0]))); // R2
  AST_NO_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> !conflict_err); // R9
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> req_ready); // R12
endmodule

bind predcmp_unit predcmp_unit_chk #(.NPRED(NPRED), .LANES(LANES)) u_chk (.*);

// File: tb/predcmp_unit_bench.sv
`timescale 1ns/1ps
module predcmp_unit_bench;
  localparam int NP = 64;
  localparam int NL = 4;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0]    req_valid = '0;
  logic             req_ready;
  logic [NL*3-1:0]  req_type = '0;
  logic [NL-1:0]    req_qp = '0, req_rel = '0, req_nat = '0;
  logic [NL*IW-1:0] req_dst1 = '0, req_dst2 = '0;
  logic [NP-1:0]    pred_q;
  logic             conflict_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NP-1:0] m_pred;
  logic          m_err;

  always #10 clk = ~clk;

  predcmp_unit u_predcmp_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_qp(req_qp), .req_rel(req_rel), .req_nat(req_nat),
    .req_dst1(req_dst1), .req_dst2(req_dst2), .pred_q(pred_q),
    .conflict_err(conflict_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lane(int l, bit v, logic [2:0] ty, bit qp, bit rel, bit nat,
                      int d1, int d2);
    req_valid[l] = v;
    req_type[l*3 +: 3] = ty;
    req_qp[l] = qp; req_rel[l] = rel; req_nat[l] = nat;
    req_dst1[l*IW +: IW] = IW'(d1);
    req_dst2[l*IW +: IW] = IW'(d2);
  endtask

  task automatic idle_all();
    for (int l = 0; l < NL; l++) lane(l, 0, 3'd0, 0, 0, 0, 0, 0);
  endtask

  // Reference model computed from the requirements
  task automatic model_apply();
    int  cnt [NP];
    bit  exa [NP];
    bit  exv [NP];
    bit  sa  [NP];
    bit  ca  [NP];
    logic [NP-1:0] nx;
    bit anyc, q, r, act, ex, v, conf;
    int d;
    logic [2:0] ty;
    for (int i = 0; i < NP; i++) begin
      cnt[i] = 0; exa[i] = 0; exv[i] = 0; sa[i] = 0; ca[i] = 0;
    end
    for (int l = 0; l < NL; l++) begin
      if (req_valid[l]) begin
        ty = req_type[l*3 +: 3];
        q  = req_qp[l];
        r  = req_rel[l] & ~req_nat[l];
        for (int t = 0; t < 2; t++) begin
          d = t ? int'(req_dst2[l*IW +: IW]) : int'(req_dst1[l*IW +: IW]);
          act = 0; ex = 0; v = 0;
          case (ty)
            3'd0: begin act = q; ex = 1; v = t ? ~r : r; end
            3'd1: begin act = 1; ex = 1; v = q & (t ? ~r : r); end
            3'd2: begin act = q & ~r; v = 0; end
            3'd3: begin act = q & r; v = 1; end
            3'd4: begin act = q & r; v = (t == 0); end
            default: act = 0;
          endcase
          if (act && d != 0) begin
            cnt[d]++;
            if (ex) begin exa[d] = 1; exv[d] = v; end
            else if (v) sa[d] = 1;
            else ca[d] = 1;
          end
        end
      end
    end
    nx = m_pred; anyc = 0;
    for (int i = 1; i < NP; i++) begin
      conf = (exa[i] && cnt[i] >= 2) || (sa[i] && ca[i]);
      if (conf) anyc = 1;
      else if (exa[i]) nx[i] = exv[i];
      else if (sa[i]) nx[i] = 1'b1;
      else if (ca[i]) nx[i] = 1'b0;
    end
    m_pred = nx;
    m_err  = anyc;
  endtask

  task automatic step(string tag);
    model_apply();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pred file"}, pred_q, m_pred);
    chk({tag, " conflict flag"}, 64'(conflict_err), 64'(m_err));
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_pred = 64'h1; m_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 ready low in reset", 64'(req_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset file", pred_q, 64'h1);
    chk("R10 reset flag", 64'(conflict_err), 64'd0);
    chk("R12 ready after reset", 64'(req_ready), 64'd1);

    // R1 plain
    idle_all(); lane(0, 1, 3'd0, 1, 1, 0, 5, 6); step("R1 plain qp1");
    chk("R1 first target", 64'(pred_q[5]), 64'd1);
    chk("R1 second target", 64'(pred_q[6]), 64'd0);
    lane(0, 1, 3'd0, 0, 0, 0, 5, 6); step("R1 plain qp0");
    chk("R1 qp0 holds", 64'(pred_q[5]), 64'd1);
    // R2 unconditional with qp 0
    lane(0, 1, 3'd1, 0, 1, 0, 5, 6); step("R2 unc qp0");
    chk("R2 first cleared", 64'(pred_q[5]), 64'd0);
    chk("R2 second cleared", 64'(pred_q[6]), 64'd0);
    // R4 / R8 OR combine
    idle_all();
    lane(0, 1, 3'd3, 1, 0, 0, 10, 11);
    lane(1, 1, 3'd3, 1, 1, 0, 10, 11); step("R4 R8 or combine");
    chk("R4 or set", 64'(pred_q[11:10]), 64'd3);
    chk("R8 no error", 64'(conflict_err), 64'd0);
    // R3 / R8 AND combine, four lanes
    for (int l = 0; l < NL; l++) lane(l, 1, 3'd2, 1, (l != 2), 0, 10, 11);
    step("R3 R8 and combine");
    chk("R3 and clear", 64'(pred_q[11:10]), 64'd0);
    // R5 OR-ANDCM
    idle_all(); lane(0, 1, 3'd3, 1, 1, 0, 13, 14); step("R5 preset");
    lane(0, 1, 3'd4, 1, 1, 0, 12, 13); step("R5 orandcm");
    chk("R5 first set", 64'(pred_q[12]), 64'd1);
    chk("R5 second clear", 64'(pred_q[13]), 64'd0);
    chk("R5 others hold", 64'(pred_q[14]), 64'd1);
    // R6 NaT
    lane(0, 1, 3'd0, 1, 1, 1, 20, 21);
    lane(1, 1, 3'd3, 1, 1, 1, 22, 23); step("R6 nat");
    chk("R6 plain as false", 64'(pred_q[21:20]), 64'd2);
    chk("R6 or suppressed", 64'(pred_q[23:22]), 64'd0);
    // R7 predicate zero
    idle_all();
    lane(0, 1, 3'd0, 1, 0, 0, 0, 24);
    lane(1, 1, 3'd1, 1, 1, 0, 0, 25); step("R7 p0");
    chk("R7 p0 reads one", 64'(pred_q[0]), 64'd1);
    chk("R7 p0 no conflict", 64'(conflict_err), 64'd0);
    chk("R7 other target written", 64'(pred_q[24]), 64'd1);
    // R9 exclusive plus one-sided
    idle_all();
    lane(0, 1, 3'd0, 1, 0, 0, 30, 31);
    lane(1, 1, 3'd3, 1, 1, 0, 30, 32); step("R9 excl mix");
    chk("R9 conflict holds", 64'(pred_q[30]), 64'd0);
    chk("R9 others update", 64'(pred_q[32:31]), 64'd3);
    chk("R9 flag raised", 64'(conflict_err), 64'd1);
    idle_all(); step("R9 flag drops");
    chk("R9 flag one cycle", 64'(conflict_err), 64'd0);
    lane(0, 1, 3'd3, 1, 1, 0, 33, 34);
    lane(1, 1, 3'd2, 1, 0, 0, 33, 35); step("R9 set and clear");
    chk("R9 set-clear holds", 64'(pred_q[33]), 64'd0);
    chk("R9 set-clear flag", 64'(conflict_err), 64'd1);
    // R11 reserved codes and invalid lanes
    idle_all();
    lane(0, 1, 3'd6, 1, 1, 0, 40, 41);
    lane(1, 0, 3'd3, 1, 1, 0, 42, 43); step("R11 no write");
    chk("R11 nothing written", 64'(pred_q[43:40]), 64'd0);

    // Constrained random traffic on few indices
    for (int n = 0; n < 3000; n++) begin
      for (int l = 0; l < NL; l++)
        lane(l, ($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             $urandom_range(0, 5) == 0,
             int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      step("R8 R9 R10 random");
    end
    idle_all(); step("R10 idle hold");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule